// File: doc/BRIEF.md
# PCM Level Meter Accumulator

This block measures the signal level on one of four time-shared PCM channels. Samples arrive one at a time with a valid strobe and a 2-bit channel tag. The block keeps only the samples whose tag matches the selected channel. In linear mode it adds up their magnitudes over a programmable number of 8 kHz sample periods. When the window closes, it latches the 15-bit total into two host-readable byte registers and raises a ready flag.

In compressed mode the block accumulates nothing. Each selected 8-bit code is copied straight into the high result register. Results that the host has not read are overwritten. Reading the high register is the acknowledge that drops the ready flag.

The sample input takes one sample in any cycle that the valid strobe is high. The block never applies back-pressure, so there is no ready output. Configuration and read strobes are plain level or pulse pins.

Top module: `pcm_level_meter`

## Requirements
- R1: After reset both result registers read 0, so the ready flag is 0.
- R2: A sample is taken only when `smp_valid` is 1 and `smp_chan` equals `cfg_sel`. A sample with any other tag leaves both registers unchanged.
- R3: In linear mode (`cfg_lin`=1), the accepted sample that completes the window latches the sum of the absolute values of the window's samples. The sum is written with result bits 6:0 in `lo_q[7:1]`, result bits 14:7 in `hi_q[7:0]`, and the ready flag `lo_q[0]` set to 1. This happens on the same clock edge that takes that sample.
- R4: A window holds `cfg_count` accepted samples. A `cfg_count` of 0 behaves as 1.
- R5: The accumulated sum saturates at 32767 and never wraps.
- R6: A one-cycle `rd_hi` pulse clears `lo_q[0]` on the next edge. If a new result latches on that same edge, the flag stays 1. `rd_lo` has no effect on either register.
- R7: A new result overwrites both registers even when the previous one was never read.
- R8: In compressed mode (`cfg_lin`=0), each accepted sample copies `smp_cmp` unchanged into `hi_q`. `lo_q` is left unchanged.
- R9: Changing `cfg_sel`, `cfg_en` or `cfg_lin` discards the partial window, and a sample in the cycle of the change is dropped. The next window starts from zero.
- R10: While `cfg_en` is 0, samples do not change either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe, one sample per high cycle |
| smp_chan | input | 2 | Channel tag of the sample |
| smp_lin | input | 16 | Signed linear sample |
| smp_cmp | input | 8 | Compressed code of the sample |
| cfg_en | input | 1 | Metering enable |
| cfg_lin | input | 1 | 1 = accumulate linear magnitudes, 0 = pass compressed codes |
| cfg_sel | input | 2 | Channel to meter |
| cfg_count | input | 8 | Samples per measurement window |
| rd_lo | input | 1 | Host read strobe for the low register |
| rd_hi | input | 1 | Host read strobe for the high register |
| lo_q | output | 8 | Result bits 6:0 in 7:1, ready flag in bit 0 |
| hi_q | output | 8 | Result bits 14:7, or the last compressed code |

## Verification
Every observable effect in this block is due exactly one clock edge after its cause. A latched result, a compressed copy and a flag clear each appear after the rising edge that takes the sample or read strobe. An ignored sample must leave the registers unchanged at that same point.

The driver changes inputs shortly after a falling edge. For each input it drives, it queues the register pair expected one edge later. The monitor compares the queue entries on the following falling edge, well away from the active edge. After any configuration change the driver leaves two idle cycles, so the dropped restart cycle never hides a sample that is meant to count.

// File: rtl/pcm_lm_pkg.sv
package pcm_lm_pkg;
  localparam int unsigned LM_SMP_W = 16;
  localparam int unsigned LM_RES_W = 15;
  localparam int unsigned LM_CMP_W = 8;
  localparam int unsigned LM_CNT_W = 8;
  localparam int unsigned LM_CH_W  = 2;

  typedef struct packed {
    logic               en;
    logic               lin;
    logic [LM_CH_W-1:0] sel;
  } lm_mode_t;
endpackage

// File: rtl/pcm_lm_rectify.sv
module pcm_lm_rectify #(
  parameter int unsigned SMP_W = 16
) (
  input  logic signed [SMP_W-1:0] smp_i,
  output logic        [SMP_W-1:0] mag_o
);
  // Two's complement negate; the most negative value maps to 2^(SMP_W-1).
  always_comb begin
    if (smp_i[SMP_W-1]) mag_o = $unsigned(-smp_i);
    else                mag_o = $unsigned(smp_i);
  end
endmodule

// File: rtl/pcm_lm_accum.sv
module pcm_lm_accum #(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned RES_W = 15,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             restart_i,
  input  logic [SMP_W-1:0] mag_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             latch_o,
  output logic [RES_W-1:0] res_o
);
  localparam int unsigned WIDE_W = ((SMP_W > RES_W) ? SMP_W : RES_W) + 1;
  localparam logic [RES_W-1:0]  RES_MAX = {RES_W{1'b1}};
  localparam logic [WIDE_W-1:0] WIDE_MAX = WIDE_W'(RES_MAX);

  logic [RES_W-1:0]  acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  eff_lim;
  logic [WIDE_W-1:0] sum_w;
  logic [CNT_W:0]    cnt_nx;
  logic              last;

  always_comb begin
    eff_lim = (limit_i == '0) ? CNT_W'(1) : limit_i;
    sum_w   = WIDE_W'(acc_q) + WIDE_W'(mag_i);
    res_o   = (sum_w > WIDE_MAX) ? RES_MAX : sum_w[RES_W-1:0];
    cnt_nx  = {1'b0, cnt_q} + (CNT_W+1)'(1);
    last    = cnt_nx >= {1'b0, eff_lim};
    latch_o = take_i && last && !restart_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take_i) begin
      if (last) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= res_o;
        cnt_q <= cnt_nx[CNT_W-1:0];
      end
    end
  end

  // R9: a configuration change empties the window
  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (acc_q == '0) && (cnt_q == '0));
  // R3: after a latch the next window starts empty
  a_r3_window_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |=> (acc_q == '0) && (cnt_q == '0));
  // R5: the running sum never wraps below the partial sum
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> (res_o >= acc_q));
endmodule

// File: rtl/pcm_lm_result.sv
module pcm_lm_result #(
  parameter int unsigned RES_W = 15,
  parameter int unsigned CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             cmp_wr_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             rd_hi_i,
  output logic [RES_W-CMP_W:0] lo_o,
  output logic [CMP_W-1:0] hi_o
);
  localparam int unsigned LO_W = RES_W - CMP_W;

  logic [LO_W-1:0] lo_res_q;
  logic            rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_res_q <= '0;
      hi_o     <= '0;
      rdy_q    <= 1'b0;
    end else if (latch_i) begin
      lo_res_q <= res_i[LO_W-1:0];
      hi_o     <= res_i[RES_W-1:LO_W];
      rdy_q    <= 1'b1;
    end else begin
      if (cmp_wr_i) hi_o  <= cmp_i;
      if (rd_hi_i)  rdy_q <= 1'b0;
    end
  end

  assign lo_o = {lo_res_q, rdy_q};

  // R3: a latch always raises the flag
  a_r3_latch_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> lo_o[0]);
  // R6: a high read with no new result drops the flag
  a_r6_rd_hi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi_i && !latch_i) |=> !lo_o[0]);
  // R6: the flag only rises on a latch
  a_r6_flag_only_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_i && !lo_o[0]) |=> !lo_o[0]);
  // R8: compressed codes land unchanged in the high register
  a_r8_cmp_copy: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_i |=> (hi_o == $past(cmp_i)) && $stable(lo_o[LO_W:1]));
  // R10: without a write neither result field moves
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_i && !cmp_wr_i) |=> $stable(hi_o) && $stable(lo_o[LO_W:1]));
endmodule

// File: rtl/pcm_level_meter.sv
module pcm_level_meter
  import pcm_lm_pkg::*;
#(
  parameter int unsigned SMP_W = LM_SMP_W,
  parameter int unsigned RES_W = LM_RES_W,
  parameter int unsigned CMP_W = LM_CMP_W,
  parameter int unsigned CNT_W = LM_CNT_W,
  parameter int unsigned CH_W  = LM_CH_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic [CH_W-1:0]         smp_chan,
  input  logic signed [SMP_W-1:0] smp_lin,
  input  logic [CMP_W-1:0]        smp_cmp,
  input  logic                    cfg_en,
  input  logic                    cfg_lin,
  input  logic [CH_W-1:0]         cfg_sel,
  input  logic [CNT_W-1:0]        cfg_count,
  input  logic                    rd_lo,
  input  logic                    rd_hi,
  output logic [RES_W-CMP_W:0]    lo_q,
  output logic [CMP_W-1:0]        hi_q
);
  logic            mode_en_q, mode_lin_q;
  logic [CH_W-1:0] mode_sel_q;
  logic            restart, hit, take, cmp_wr, latch;
  logic [SMP_W-1:0] mag;
  logic [RES_W-1:0] res;
  logic            rd_lo_unused;

  assign rd_lo_unused = rd_lo; // low register reads carry no side effect

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en_q  <= 1'b0;
      mode_lin_q <= 1'b0;
      mode_sel_q <= '0;
    end else begin
      mode_en_q  <= cfg_en;
      mode_lin_q <= cfg_lin;
      mode_sel_q <= cfg_sel;
    end
  end

  always_comb begin
    restart = (cfg_en != mode_en_q) || (cfg_lin != mode_lin_q) || (cfg_sel != mode_sel_q);
    hit     = smp_valid && cfg_en && (smp_chan == cfg_sel) && !restart;
    take    = hit && cfg_lin;
    cmp_wr  = hit && !cfg_lin;
  end

  pcm_lm_rectify #(.SMP_W(SMP_W)) u_rect (
    .smp_i (smp_lin),
    .mag_o (mag)
  );

  pcm_lm_accum #(.SMP_W(SMP_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take),
    .restart_i (restart),
    .mag_i     (mag),
    .limit_i   (cfg_count),
    .latch_o   (latch),
    .res_o     (res)
  );

  pcm_lm_result #(.RES_W(RES_W), .CMP_W(CMP_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_i  (latch),
    .res_i    (res),
    .cmp_wr_i (cmp_wr),
    .cmp_i    (smp_cmp),
    .rd_hi_i  (rd_hi),
    .lo_o     (lo_q),
    .hi_o     (hi_q)
  );

  // R2: samples tagged for another channel leave the result fields alone
  a_r2_other_chan_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_chan != cfg_sel)) |=> $stable(hi_q) && $stable(lo_q[RES_W-CMP_W:1]));
  // R10: while disabled, samples cause no register change
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !rd_hi) |=> $stable(hi_q) && $stable(lo_q));
endmodule

// File: tb/pcm_level_meter_tb.sv
module pcm_level_meter_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [1:0]        smp_chan = '0;
  logic signed [15:0] smp_lin = '0;
  logic [7:0]        smp_cmp = '0;
  logic              cfg_en = 1'b0, cfg_lin = 1'b1;
  logic [1:0]        cfg_sel = '0;
  logic [7:0]        cfg_count = 8'd1;
  logic              rd_lo = 1'b0, rd_hi = 1'b0;
  logic [7:0]        lo_q, hi_q;

  always #2.5 clk = ~clk;

  pcm_level_meter u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_lin(smp_lin), .smp_cmp(smp_cmp), .cfg_en(cfg_en), .cfg_lin(cfg_lin),
    .cfg_sel(cfg_sel), .cfg_count(cfg_count), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .lo_q(lo_q), .hi_q(hi_q)
  );

  typedef struct {
    int         due;
    logic [7:0] lo;
    logic [7:0] hi;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] lo_e = '0, hi_e = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every item due at this falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (lo_q !== e.lo || hi_q !== e.hi) begin
          n_bad++;
          $display("FAIL %s: lo=%02h hi=%02h expected lo=%02h hi=%02h",
                   e.tag, lo_q, hi_q, e.lo, e.hi);
        end
      end
    end
  end

  function automatic logic [7:0] mk_lo(int r, bit f);
    logic [14:0] v;
    v = 15'(r);
    return {v[6:0], f};
  endfunction
  function automatic logic [7:0] mk_hi(int r);
    logic [14:0] v;
    v = 15'(r);
    return v[14:7];
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.due = cyc + 1; e.lo = lo_e; e.hi = hi_e; e.tag = tag;
    q.push_back(e);
  endtask

  // one cycle of stimulus, then queue the expectation due one edge later
  task automatic step(bit v, logic [1:0] ch, int lin, logic [7:0] cmp,
                      bit rl, bit rh, string tag);
    @(negedge clk); #1;
    smp_valid = v; smp_chan = ch; smp_lin = 16'(lin); smp_cmp = cmp;
    rd_lo = rl; rd_hi = rh;
    push(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 0, 8'h00, 0, 0, "idle");
  endtask

  task automatic setcfg(bit en, bit lin, logic [1:0] sel, logic [7:0] cnt);
    @(negedge clk); #1;
    smp_valid = 0; rd_lo = 0; rd_hi = 0;
    cfg_en = en; cfg_lin = lin; cfg_sel = sel; cfg_count = cnt;
    push("cfg");
    idle(2);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    push("R1 reset state");

    // R3 R2: window of 3 on channel 2, a channel-1 sample in between
    setcfg(1, 1, 2'd2, 8'd3);
    step(1, 2'd2, 100, 8'h00, 0, 0, "R3 partial");
    step(1, 2'd1, 5000, 8'h00, 0, 0, "R2 other channel ignored");
    step(1, 2'd2, -200, 8'h00, 0, 0, "R3 partial");
    lo_e = mk_lo(600, 1); hi_e = mk_hi(600);
    step(1, 2'd2, 300, 8'h00, 0, 0, "R3 sum latched");

    // R6 reads
    step(0, 2'd0, 0, 8'h00, 1, 0, "R6 rd_lo no effect");
    lo_e = mk_lo(600, 0);
    step(0, 2'd0, 0, 8'h00, 0, 1, "R6 rd_hi clears flag");

    // R4 count 0 behaves as 1, R7 overwrite
    setcfg(1, 1, 2'd2, 8'd0);
    lo_e = mk_lo(7, 1); hi_e = mk_hi(7);
    step(1, 2'd2, -7, 8'h00, 0, 0, "R4 count zero single sample");
    lo_e = mk_lo(9, 1);
    step(1, 2'd2, 9, 8'h00, 0, 0, "R7 unread overwritten");
    lo_e = mk_lo(5, 1);
    step(1, 2'd2, 5, 8'h00, 0, 1, "R6 new result wins over rd_hi");
    lo_e = mk_lo(5, 0);
    step(0, 2'd0, 0, 8'h00, 0, 1, "R6 rd_hi clears");

    // R5 saturation
    setcfg(1, 1, 2'd2, 8'd4);
    step(1, 2'd2, -32768, 8'h00, 0, 0, "R5 partial");
    step(1, 2'd2, -32768, 8'h00, 0, 0, "R5 partial");
    step(1, 2'd2, 1, 8'h00, 0, 0, "R5 partial");
    lo_e = mk_lo(32767, 1); hi_e = mk_hi(32767);
    step(1, 2'd2, 1, 8'h00, 0, 0, "R5 saturated");
    lo_e = mk_lo(32767, 0);
    step(0, 2'd0, 0, 8'h00, 0, 1, "R6 rd_hi clears");

    // R9 restart on select change
    setcfg(1, 1, 2'd2, 8'd3);
    step(1, 2'd2, 1000, 8'h00, 0, 0, "R9 partial");
    step(1, 2'd2, 1000, 8'h00, 0, 0, "R9 partial");
    setcfg(1, 1, 2'd3, 8'd3);
    setcfg(1, 1, 2'd2, 8'd3);
    step(1, 2'd2, 10, 8'h00, 0, 0, "R9 fresh window");
    step(1, 2'd2, 20, 8'h00, 0, 0, "R9 fresh window");
    lo_e = mk_lo(60, 1); hi_e = mk_hi(60);
    step(1, 2'd2, 30, 8'h00, 0, 0, "R9 partial discarded");

    // R10 disabled
    setcfg(0, 1, 2'd2, 8'd1);
    step(1, 2'd2, 500, 8'h11, 0, 0, "R10 disabled ignores sample");
    step(1, 2'd2, 500, 8'h11, 0, 0, "R10 disabled ignores sample");

    // R8 compressed pass-through
    setcfg(1, 0, 2'd2, 8'd1);
    hi_e = 8'hA5;
    step(1, 2'd2, 4000, 8'hA5, 0, 0, "R8 code copied");
    step(1, 2'd0, 4000, 8'h33, 0, 0, "R2 R8 other channel ignored");
    hi_e = 8'h5A;
    step(1, 2'd2, 4000, 8'h5A, 0, 0, "R8 code copied");
    lo_e = mk_lo(60, 0);
    step(0, 2'd0, 0, 8'h00, 0, 1, "R6 rd_hi clears in compressed mode");

    idle(3);
    done = 1;
    finish_run();
  end
endmodule